// File: doc/BRIEF.md
# Two-Slice Carry-Lookahead Adder-Subtractor

This block adds or subtracts two 2N-bit operands in a single combinational pass. It is built from two identical N-bit slices. Each slice forms generate, propagate and half-sum terms for its bits and runs its own carry chain through them. The low slice's carry-out feeds the high slice's carry-in directly. A single subtract control inverts B in both slices. The same control also forces a one into the low slice's carry-in, which supplies the +1 of two's complement exactly once.

In add mode, a carry-in input feeds the low slice, so a wider datapath can chain this block. The outputs are:

- the 2N-bit result;
- the carry-out of each slice;
- the signed overflow of the full-width result.

No slice inverts its own carry-in. The carry between the two slices therefore passes through unchanged in both modes.

Top module: `addsub_cascade`

## Requirements
- R1: With sub_en=0, sum equals (op_a + op_b + carry_in) modulo 2^(2N).
- R2: With sub_en=1, sum equals (op_a - op_b) modulo 2^(2N). For example, 300-50 gives 250 and 50-250 gives 0xFF38 at N=8.
- R3: With sub_en=1, the value of carry_in has no effect on any output.
- R4: cout_lo is the carry out of bit N-1. In add mode it is 1 when the low N bits of op_a plus the low N bits of op_b plus carry_in reach 2^N. In subtract mode it is 1 when the low half of op_a is greater than or equal to the low half of op_b, as unsigned values.
- R5: cout_hi is the carry out of bit 2N-1. In add mode it is 1 when op_a + op_b + carry_in reaches 2^(2N). In subtract mode it is 1 when op_a >= op_b as unsigned values.
- R6: ovf is 1 exactly when the signed two's-complement result of the operation falls outside the 2N-bit signed range.
- R7: A carry or borrow crosses the slice boundary without inversion. At N=8, 0x00FF+1 gives 0x0100 and 0x0100-1 gives 0x00FF.
- R8: The outputs depend only on the present inputs. There is no clock and no stored state, and all-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 2*SLICE_W | Minuend or first addend |
| op_b | input | 2*SLICE_W | Subtrahend or second addend |
| sub_en | input | 1 | 1 selects op_a - op_b, 0 selects addition |
| carry_in | input | 1 | Carry into the low slice in add mode |
| sum | output | 2*SLICE_W | Result |
| cout_lo | output | 1 | Carry out of the low slice |
| cout_hi | output | 1 | Carry out of the high slice |
| ovf | output | 1 | Signed overflow of the full-width result |

## Verification
Checks that hold for any input are evaluated whenever an input changes:

- the full-width result and top carry against plain arithmetic;
- the low-slice carry against a half-width sum;
- the top carry in subtract mode against an unsigned compare;
- the overflow flag against the operand and result signs.

Some behaviours show only in the bench's chosen stimuli. These are the worked subtraction cases, the carry and borrow that cross the slice boundary, carry_in being ignored during subtraction, and the all-zero idle state.

// File: rtl/addsub_cascade.sv
module addsub_cascade #(
  parameter int SLICE_W = 8
) (
  input  logic [2*SLICE_W-1:0] op_a,
  input  logic [2*SLICE_W-1:0] op_b,
  input  logic                 sub_en,
  input  logic                 carry_in,
  output logic [2*SLICE_W-1:0] sum,
  output logic                 cout_lo,
  output logic                 cout_hi,
  output logic                 ovf
);
  localparam int SLICES = 2;
  localparam int W      = SLICES * SLICE_W;

  logic [W-1:0] b_eff, gen, prop, half;

  assign b_eff = op_b ^ {W{sub_en}};
  assign gen   = op_a & b_eff;
  assign prop  = op_a | b_eff;
  assign half  = op_a ^ b_eff;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    localparam int BASE = s * SLICE_W;
    logic               cin_s;
    logic               cout_s;
    logic [SLICE_W-1:0] cbit;

    if (s == 0) begin : g_low
      assign cin_s = sub_en | carry_in;
    end else begin : g_up
      assign cin_s = g_slice[s-1].cout_s;
    end

    always_comb begin
      logic c;
      c = cin_s;
      for (int i = 0; i < SLICE_W; i++) begin
        cbit[i] = c;
        c = gen[BASE+i] | (prop[BASE+i] & c);
      end
      cout_s = c;
    end

    assign sum[BASE +: SLICE_W] = half[BASE +: SLICE_W] ^ cbit;
  end

  assign cout_lo = g_slice[0].cout_s;
  assign cout_hi = g_slice[SLICES-1].cout_s;
  assign ovf     = g_slice[SLICES-1].cbit[SLICE_W-1] ^ g_slice[SLICES-1].cout_s;
endmodule

// File: rtl/addsub_cascade_chk.sv
module addsub_cascade_chk #(
  parameter int SLICE_W = 8
) (
  input logic [2*SLICE_W-1:0] op_a,
  input logic [2*SLICE_W-1:0] op_b,
  input logic                 sub_en,
  input logic                 carry_in,
  input logic [2*SLICE_W-1:0] sum,
  input logic                 cout_lo,
  input logic                 cout_hi,
  input logic                 ovf
);
  localparam int W = 2 * SLICE_W;

  logic [W-1:0]       bx;
  logic               cx;
  logic [W:0]         full_ref;
  logic [SLICE_W:0]   low_ref;
  logic               ovf_ref;

  always_comb begin
    bx       = sub_en ? ~op_b : op_b;
    cx       = sub_en ? 1'b1 : carry_in;
    full_ref = {1'b0, op_a} + {1'b0, bx} + {{W{1'b0}}, cx};
    low_ref  = {1'b0, op_a[SLICE_W-1:0]} + {1'b0, bx[SLICE_W-1:0]} + {{SLICE_W{1'b0}}, cx};
    ovf_ref  = (op_a[W-1] == bx[W-1]) && (full_ref[W-1] != op_a[W-1]);

    // R1 R2 R3
    sum_match_chk: assert ({cout_hi, sum} == full_ref)
      else $error("sum/carry mismatch");
    // R4
    low_carry_chk: assert (cout_lo == low_ref[SLICE_W])
      else $error("low slice carry mismatch");
    // R5
    borrow_chk: assert (!sub_en || (cout_hi == (op_a >= op_b)))
      else $error("subtract carry mismatch");
    // R6
    overflow_chk: assert (ovf == ovf_ref)
      else $error("overflow mismatch");
  end
endmodule

bind addsub_cascade addsub_cascade_chk #(.SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/tb_addsub_cascade.sv
module tb_addsub_cascade;
  localparam int N = 8;
  localparam int W = 2 * N;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] op_a, op_b, sum;
  logic sub_en, carry_in, cout_lo, cout_hi, ovf;
  int total = 0, bad = 0;
  bit finished = 0;

  addsub_cascade #(.SLICE_W(N)) dut (.*);

  // a(16) b(16) sub(1) cin(1) expected sum(16)
  localparam logic [49:0] VEC [10] = '{
    {16'd300,   16'd50,   1'b1, 1'b0, 16'd250},
    {16'd350,   16'd50,   1'b1, 1'b0, 16'd300},
    {16'd50,    16'd250,  1'b1, 1'b0, 16'hFF38},
    {16'd50,    16'd250,  1'b0, 1'b0, 16'd300},
    {16'hFFFF,  16'h0001, 1'b0, 1'b0, 16'h0000},
    {16'h00FF,  16'h0001, 1'b0, 1'b0, 16'h0100},
    {16'h0100,  16'h0001, 1'b1, 1'b0, 16'h00FF},
    {16'h1234,  16'h1234, 1'b1, 1'b1, 16'h0000},
    {16'h7FFF,  16'h0001, 1'b0, 1'b0, 16'h8000},
    {16'h0005,  16'h0003, 1'b0, 1'b1, 16'h0009}
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input logic c);
    @(negedge clk);
    op_a = a; op_b = b; sub_en = s; carry_in = c;
    #1;
  endtask

  task automatic check_ref(input string tag);
    int ua, ub, sa, sb, r, lo;
    logic exp_lo, exp_hi, exp_ovf;
    logic [W-1:0] exp_sum;
    ua = int'(op_a); ub = int'(op_b);
    sa = (ua >= 32768) ? ua - 65536 : ua;
    sb = (ub >= 32768) ? ub - 65536 : ub;
    if (sub_en) begin
      exp_sum = W'(ua - ub);
      exp_hi  = ua >= ub;
      exp_lo  = (ua % 256) >= (ub % 256);
      r = sa - sb;
    end else begin
      exp_sum = W'(ua + ub + int'(carry_in));
      exp_hi  = (ua + ub + int'(carry_in)) >= 65536;
      lo      = (ua % 256) + (ub % 256) + int'(carry_in);
      exp_lo  = lo >= 256;
      r = sa + sb + int'(carry_in);
    end
    exp_ovf = (r > 32767) || (r < -32768);
    chk({tag, (sub_en ? " R2 sum" : " R1 sum")}, sum, exp_sum);
    chk({tag, " R4 cout_lo"}, W'(cout_lo), W'(exp_lo));
    chk({tag, " R5 cout_hi"}, W'(cout_hi), W'(exp_hi));
    chk({tag, " R6 ovf"}, W'(ovf), W'(exp_ovf));
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s0;
    logic l0, h0, v0;

    // R8 idle state
    drive('0, '0, 1'b0, 1'b0);
    chk("R8 zero sum", sum, '0);
    chk("R8 zero flags", W'({cout_lo, cout_hi, ovf}), '0);

    foreach (VEC[k]) begin
      drive(VEC[k][49:34], VEC[k][33:18], VEC[k][17], VEC[k][16]);
      chk(VEC[k][17] ? "R2 table" : "R1 table", sum, VEC[k][15:0]);
      check_ref("table");
    end

    // R7 boundary crossing both ways
    drive(16'h00FF, 16'h0001, 1'b0, 1'b0);
    chk("R7 carry up", sum, 16'h0100);
    chk("R7 cout_lo", W'(cout_lo), W'(1));
    drive(16'h0100, 16'h0001, 1'b1, 1'b0);
    chk("R7 borrow down", sum, 16'h00FF);
    chk("R7 cout_lo borrow", W'(cout_lo), W'(0));

    // R3 carry_in ignored in subtract mode
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] a, b;
      a = W'($urandom); b = W'($urandom);
      drive(a, b, 1'b1, 1'b0);
      s0 = sum; l0 = cout_lo; h0 = cout_hi; v0 = ovf;
      drive(a, b, 1'b1, 1'b1);
      chk("R3 sum", sum, s0);
      chk("R3 flags", W'({cout_lo, cout_hi, ovf}), W'({l0, h0, v0}));
    end

    // R6 signed overflow corners
    drive(16'h8000, 16'h0001, 1'b1, 1'b0);
    chk("R6 neg underflow", W'(ovf), W'(1));
    drive(16'h8000, 16'hFFFF, 1'b1, 1'b0);
    chk("R6 no overflow", W'(ovf), W'(0));

    for (int k = 0; k < 400; k++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), 1'($urandom));
      check_ref("random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule